// File: doc/BRIEF.md
# Interrupt Request Aggregator

This block collects a bank of interrupt request lines and presents one combined request to a parent interrupt controller. Each line is first passed through a synchroniser. A per-line trigger stage then qualifies it as a level, active high or low, or as an edge, rising or falling. The result lands in a status register. A request is pending when its status bit and its enable bit are both set. The output is high whenever any line is pending.

Software reaches the configuration through a word-wide register port. A write is a single-cycle strobe. Reads are combinational and have no side effects. Status bits that came from edges stay set until software clears them with a write-one-to-clear access. A companion write-one-to-set access lets software raise an interrupt itself.

For level lines the status bit follows the live, qualified input, so a clear cannot hold it off. A handler therefore has to remove the cause at the source.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is active, status, enable, polarity and edge-select all read 0 and irq_o is 0.
- R2: Registers sit at word-aligned byte offsets: 0x00 status (read only), 0x04 enable, 0x08 set, 0x0C clear, 0x10 polarity, 0x14 edge-select. Enable, polarity and edge-select read back what was written. The set and clear offsets read 0. Bit n of every register belongs to request line n.
- R3: When edge-select bit n is 0, line n is level sensitive. Polarity 1 means active high and polarity 0 means active low. Status bit n shows the qualified input three clock edges after the pin changes (two synchroniser flops, then the status flop). A clear write has no lasting effect on such a line.
- R4: When edge-select bit n is 1, line n is edge sensitive. Polarity 1 latches rising edges and polarity 0 latches falling edges. The status bit stays set after the input returns to its idle level.
- R5: Writing 1 to bit n at offset 0x0C clears the latched status of edge line n on that clock edge. Bits written as 0 leave their status unchanged.
- R6: Writing 1 to bit n at offset 0x08 sets status bit n on that clock edge. Bits written as 0 have no effect. On a level line the forced value lasts for that one cycle only.
- R7: If an edge is detected on a line in the same cycle that a clear write hits that line, the status bit stays set.
- R8: irq_o is the OR of status AND enable, with no added delay. Writing 0 to the enable register masks every line from the next cycle on.
- R9: Reads never change state. Reads from unmapped or misaligned addresses return 0. Writes to the status offset, to unmapped addresses or to misaligned addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_LINES | Asynchronous interrupt request lines |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wdata_i | input | NUM_LINES | Write data |
| bus_rdata_o | output | NUM_LINES | Combinational read data for bus_addr_i |
| irq_o | output | 1 | Combined request to the parent controller |

## Verification
A corrupted status or previous-sample flop appears on the status read and on irq_o one edge after the faulty update. Status and irq_o are therefore compared at the exact cycle they should change, and not after a long settling time. Dropping or adding a synchroniser stage moves level tracking by one cycle, which the level-latency check exposes. A clear that wins over a coincident edge loses that edge for good, so the bench times a clear write onto the edge's detection cycle. Mixed polarity and edge-select patterns catch a mode-decode fault, because it shows on only some of the bits.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Word indices of the register bank (byte offset / 4)
    localparam int unsigned WIDX_STATUS = 0;
    localparam int unsigned WIDX_ENABLE = 1;
    localparam int unsigned WIDX_SET    = 2;
    localparam int unsigned WIDX_CLEAR  = 3;
    localparam int unsigned WIDX_POL    = 4;
    localparam int unsigned WIDX_EDGE   = 5;

    // Per-line trigger state
    typedef struct packed {
        logic prev;    // synchronised sample from the previous cycle
        logic status;  // latched or live status
    } line_state_t;

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irqagg_line.sv
module irqagg_line
    import irqagg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic pol_i,
    input  logic edge_sel_i,
    input  logic set_i,
    input  logic clr_i,
    output logic status_o
);

    line_state_t st_d, st_q;
    logic        level_hit;
    logic        edge_hit;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_i;
        level_hit = ~(sync_i ^ pol_i);
        edge_hit  = pol_i ? (sync_i & ~st_q.prev) : (~sync_i & st_q.prev);
        if (edge_sel_i) begin
            // a detected edge beats a coincident clear
            st_d.status = edge_hit | set_i | (st_q.status & ~clr_i);
        end else begin
            st_d.status = level_hit | set_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 32,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req_i,
    input  logic                 bus_we_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [NUM_LINES-1:0] bus_wdata_i,
    output logic [NUM_LINES-1:0] bus_rdata_o,
    output logic                 irq_o
);

    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] IDX_STATUS = IDX_W'(WIDX_STATUS);
    localparam logic [IDX_W-1:0] IDX_ENABLE = IDX_W'(WIDX_ENABLE);
    localparam logic [IDX_W-1:0] IDX_SET    = IDX_W'(WIDX_SET);
    localparam logic [IDX_W-1:0] IDX_CLEAR  = IDX_W'(WIDX_CLEAR);
    localparam logic [IDX_W-1:0] IDX_POL    = IDX_W'(WIDX_POL);
    localparam logic [IDX_W-1:0] IDX_EDGE   = IDX_W'(WIDX_EDGE);

    typedef struct packed {
        logic [NUM_LINES-1:0] en;
        logic [NUM_LINES-1:0] pol;
        logic [NUM_LINES-1:0] edge_sel;
    } cfg_t;

    cfg_t                 cfg_d, cfg_q;
    logic [IDX_W-1:0]     widx;
    logic                 aligned;
    logic                 wr_ok;
    logic [NUM_LINES-1:0] set_mask;
    logic [NUM_LINES-1:0] clr_mask;
    logic [NUM_LINES-1:0] sync_w;
    logic [NUM_LINES-1:0] status_w;

    assign widx    = bus_addr_i[ADDR_W-1:2];
    assign aligned = (bus_addr_i[1:0] == 2'b00);
    assign wr_ok   = bus_we_i && aligned;

    // ---------------- register bank: next state ----------------
    always_comb begin
        cfg_d    = cfg_q;
        set_mask = '0;
        clr_mask = '0;
        if (wr_ok) begin
            case (widx)
                IDX_ENABLE: cfg_d.en       = bus_wdata_i;
                IDX_POL:    cfg_d.pol      = bus_wdata_i;
                IDX_EDGE:   cfg_d.edge_sel = bus_wdata_i;
                IDX_SET:    set_mask       = bus_wdata_i;
                IDX_CLEAR:  clr_mask       = bus_wdata_i;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // ---------------- read mux (no side effects) ----------------
    always_comb begin
        bus_rdata_o = '0;
        if (aligned) begin
            case (widx)
                IDX_STATUS: bus_rdata_o = status_w;
                IDX_ENABLE: bus_rdata_o = cfg_q.en;
                IDX_POL:    bus_rdata_o = cfg_q.pol;
                IDX_EDGE:   bus_rdata_o = cfg_q.edge_sel;
                default:    bus_rdata_o = '0;
            endcase
        end
    end

    // ---------------- synchroniser and per-line triggers ----------------
    irqagg_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (req_i),
        .sync_o  (sync_w)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irqagg_line u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .sync_i     (sync_w[g]),
            .pol_i      (cfg_q.pol[g]),
            .edge_sel_i (cfg_q.edge_sel[g]),
            .set_i      (set_mask[g]),
            .clr_i      (clr_mask[g]),
            .status_o   (status_w[g])
        );
    end

    assign irq_o = |(status_w & cfg_q.en);

    // ---------------- assertions ----------------
    AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && widx == IDX_ENABLE && bus_wdata_i == '0) |=> !irq_o); // R8

    AST_SET_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && widx == IDX_SET) |=> ((status_w & $past(bus_wdata_i)) == $past(bus_wdata_i))); // R6

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_w) & $past(cfg_q.edge_sel) & ~$past(clr_mask) & ~status_w) == '0)); // R4

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_w & ~$past(cfg_q.edge_sel) & ~$past(set_mask)) ==
                  (~($past(sync_w) ^ $past(cfg_q.pol)) & ~$past(cfg_q.edge_sel) & ~$past(set_mask)))); // R3

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!aligned || widx > IDX_EDGE) |-> (bus_rdata_o == '0)); // R9

    AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && widx == IDX_STATUS) |=> $stable(cfg_q)); // R9

endmodule

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;

    localparam int N = 32;
    localparam logic [4:0] A_STAT = 5'h00, A_EN = 5'h04, A_SET = 5'h08,
                           A_CLR = 5'h0C, A_POL = 5'h10, A_EDG = 5'h14;

    // {polarity, edge-select, starting input, final input}
    localparam logic [31:0] VEC [6][4] = '{
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'hA5A5_0F0F},
        '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_FFFF},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h00FF_00FF, 32'h0F0F_0F0F},
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'hF0F0_F0F0},
        '{32'hAAAA_AAAA, 32'hCCCC_CCCC, 32'h1234_5678, 32'h8765_4321},
        '{32'h0F0F_0F0F, 32'h3333_3333, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         we = 1'b0;
    logic [4:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq;
    int           n_chk = 0;
    int           n_bad = 0;
    logic [N-1:0] tmp;

    always #2 clk = ~clk;

    irq_aggregator u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [N-1:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [N-1:0] expect_status(input logic [N-1:0] p, input logic [N-1:0] e,
                                                   input logic [N-1:0] a, input logic [N-1:0] b);
        return (e & ((p & ~a & b) | (~p & a & ~b))) | (~e & ~(b ^ p));
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset values
        settle(3);
        rd(A_STAT, tmp); check("R1 status", tmp, '0);
        rd(A_EN,   tmp); check("R1 enable", tmp, '0);
        rd(A_POL,  tmp); check("R1 polarity", tmp, '0);
        rd(A_EDG,  tmp); check("R1 edge", tmp, '0);
        check("R1 irq", {31'd0, irq}, '0);
        @(negedge clk) rst_n = 1'b1;

        // R2: readback and write-only offsets
        wr(A_EN, 32'hDEAD_BEEF);  rd(A_EN, tmp);  check("R2 enable", tmp, 32'hDEAD_BEEF);
        wr(A_POL, 32'h1357_9BDF); rd(A_POL, tmp); check("R2 polarity", tmp, 32'h1357_9BDF);
        wr(A_EDG, 32'h0F1E_2D3C); rd(A_EDG, tmp); check("R2 edge", tmp, 32'h0F1E_2D3C);
        rd(A_SET, tmp); check("R2 set reads 0", tmp, '0);
        rd(A_CLR, tmp); check("R2 clear reads 0", tmp, '0);
        wr(A_EN, '0);

        // R3/R4: vector table of trigger modes
        for (int v = 0; v < 6; v++) begin
            wr(A_POL, VEC[v][0]);
            wr(A_EDG, VEC[v][1]);
            @(negedge clk) req = VEC[v][2];
            settle(5);
            wr(A_CLR, '1);
            @(negedge clk) req = VEC[v][3];
            settle(5);
            rd(A_STAT, tmp);
            check($sformatf("R3/R4 vector %0d", v), tmp,
                  expect_status(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]));
        end

        // all lines rising-edge, quiet and cleared
        wr(A_POL, '1); wr(A_EDG, '1);
        @(negedge clk) req = '0;
        settle(5);
        wr(A_CLR, '1);

        // R4: edge latched after input returns low
        @(negedge clk) req[0] = 1'b1;
        settle(5);
        @(negedge clk) req[0] = 1'b0;
        settle(5);
        rd(A_STAT, tmp); check("R4 hold after pulse", tmp, 32'h1);

        // R8: output gating by enable
        wr(A_EN, 32'h1); @(negedge clk); check("R8 enabled pending", {31'd0, irq}, 32'h1);
        wr(A_EN, 32'h2); @(negedge clk); check("R8 other enable", {31'd0, irq}, 32'h0);
        wr(A_EN, '1);    @(negedge clk); check("R8 all enabled", {31'd0, irq}, 32'h1);
        wr(A_EN, '0);    @(negedge clk); check("R8 mask all", {31'd0, irq}, 32'h0);

        // R6: software set
        wr(A_SET, 32'h2); rd(A_STAT, tmp); check("R6 set bit1", tmp, 32'h3);
        // R5: partial clear, zeros leave bits alone
        wr(A_CLR, 32'h1); rd(A_STAT, tmp); check("R5 partial clear", tmp, 32'h2);
        wr(A_CLR, '1);    rd(A_STAT, tmp); check("R5 clear all", tmp, 32'h0);

        // R9: writes to status, unmapped or misaligned change nothing; reads are idempotent
        wr(A_STAT, '1); wr(5'h18, '1); wr(5'h09, '1);
        rd(A_STAT, tmp); check("R9 ignored writes", tmp, 32'h0);
        rd(5'h18, tmp); check("R9 unmapped read", tmp, '0);
        rd(5'h11, tmp); check("R9 misaligned read", tmp, '0);
        rd(A_POL, tmp); check("R9 polarity kept", tmp, '1);

        // R7: edge coincides with clear write
        @(negedge clk) req[2] = 1'b1;
        @(negedge clk);
        wr(A_CLR, 32'h4);
        rd(A_STAT, tmp); check("R7 edge beats clear", tmp, 32'h4);
        rd(A_STAT, tmp); check("R9 repeat read", tmp, 32'h4);
        wr(A_CLR, '1);

        // R3: level line ignores clear, and tracks with three-edge latency
        wr(A_EDG, 32'hFFFF_FFEF);
        @(negedge clk) req[4] = 1'b1;
        settle(5);
        wr(A_CLR, '1);
        rd(A_STAT, tmp); check("R3 level not cleared", tmp, 32'h10);
        @(negedge clk) req[4] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1 addr = A_STAT;
        #1 check("R3 latency old value", rdata, 32'h10);
        @(negedge clk);
        #1 check("R3 latency new value", rdata, 32'h0);

        finish_run();
    end

endmodule